// File: doc/BRIEF.md
# Three-Bit Bidirectional Shift Register with Mode Select

This block is a small parallel-out register. On each rising clock edge it shifts its contents one place toward the low end or the high end, keeps them, or clears them to zero. A 2-bit mode input selects the action. Two serial inputs supply the bit that enters the register. One feeds the high end during a right shift, and the other feeds the low end during a left shift. The bit that leaves at the far end is dropped. The parallel contents are always visible on the output.

Internally, a decoder turns the mode code into a one-hot selection. Each bit position then takes its next value through its own 4-to-1 choice among: zero, its upper neighbour, its lower neighbour, and itself. A synchronous active-high reset overrides every mode.

Top module: `bidir_shift3`

## Requirements
- R1: While `rst` is high at a rising edge, `q` becomes all zeros after that edge, whatever `mode` and the serial inputs are.
- R2: With `mode` = 2'b00 at a rising edge, `q` becomes all zeros after that edge.
- R3: With `mode` = 2'b01 at a rising edge, the register shifts right. The new `q[2]` is `ser_hi`, the new `q[1]` is the old `q[2]`, and the new `q[0]` is the old `q[1]`.
- R4: With `mode` = 2'b10 at a rising edge, the register shifts left. The new `q[0]` is `ser_lo`, the new `q[1]` is the old `q[0]`, and the new `q[2]` is the old `q[1]`.
- R5: With `mode` = 2'b11 at a rising edge, `q` keeps its value, and neither serial input has any effect on it.
- R6: During a right shift `ser_lo` has no effect on `q`, and during a left shift `ser_hi` has no effect on `q`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 00 clear, 01 shift right, 10 shift left, 11 hold |
| ser_hi | input | 1 | Bit entering q[2] on a right shift |
| ser_lo | input | 1 | Bit entering q[0] on a left shift |
| q | output | 3 | Current register contents |

## Verification
Two functions can be requested in the same cycle in two ways.

- **Reset against mode.** Reset can be asserted while the mode asks for a shift or a hold. The bench provokes this both in directed steps and at random, and judges that the reset wins, so `q` must read zero after that edge.
- **Shift against the opposite serial input.** A shift can occur while the serial input for the other direction toggles. The bench drives the unused serial input opposite to the used one and checks that only the selected input appears in `q`.

A behavioural integer model, built from shifts and masks, is compared with `q` on every cycle.

// File: rtl/shreg_pkg.sv
package shreg_pkg;

    typedef enum logic [1:0] {
        MODE_CLEAR = 2'b00,
        MODE_RIGHT = 2'b01,
        MODE_LEFT  = 2'b10,
        MODE_HOLD  = 2'b11
    } shreg_mode_e;

    typedef struct packed {
        logic clr;
        logic rsh;
        logic lsh;
        logic keep;
    } shreg_sel_t;

    function automatic shreg_sel_t decode_mode(input logic [1:0] code);
        shreg_sel_t s;
        s = '0;
        case (shreg_mode_e'(code))
            MODE_CLEAR: s.clr  = 1'b1;
            MODE_RIGHT: s.rsh  = 1'b1;
            MODE_LEFT:  s.lsh  = 1'b1;
            default:    s.keep = 1'b1;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/shreg_mode_dec.sv
module shreg_mode_dec
    import shreg_pkg::*;
(
    input  logic [1:0] mode,
    output shreg_sel_t sel
);

    always_comb begin
        sel = decode_mode(mode);
    end

    always_comb begin
        if (!$isunknown(mode)) begin
            AST_SEL_ONE_HOT: assert ($countones(sel) == 1); // R5
        end
    end

endmodule

// File: rtl/shreg_bit_mux.sv
module shreg_bit_mux
    import shreg_pkg::*;
(
    input  shreg_sel_t sel,
    input  logic       from_upper,
    input  logic       from_lower,
    input  logic       self_val,
    output logic       d
);

    always_comb begin
        d = (sel.rsh  & from_upper)
          | (sel.lsh  & from_lower)
          | (sel.keep & self_val);
    end

endmodule

// File: rtl/bidir_shift3.sv
module bidir_shift3
    import shreg_pkg::*;
#(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode,
    input  logic             ser_hi,
    input  logic             ser_lo,
    output logic [WIDTH-1:0] q
);

    localparam int MSB = WIDTH - 1;

    shreg_sel_t       sel;
    logic [WIDTH-1:0] nxt;
    logic [WIDTH-1:0] state_q;

    shreg_mode_dec u_dec (
        .mode (mode),
        .sel  (sel)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic up_src;
        logic lo_src;

        if (i == MSB) begin : g_top
            assign up_src = ser_hi;
        end else begin : g_mid_up
            assign up_src = state_q[i+1];
        end

        if (i == 0) begin : g_bottom
            assign lo_src = ser_lo;
        end else begin : g_mid_lo
            assign lo_src = state_q[i-1];
        end

        shreg_bit_mux u_mux (
            .sel        (sel),
            .from_upper (up_src),
            .from_lower (lo_src),
            .self_val   (state_q[i]),
            .d          (nxt[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= nxt;
        end
    end

    assign q = state_q;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (q == '0)); // R1

    AST_CLEAR_MODE: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b00) |=> (q == '0)); // R2

    AST_SHIFT_RIGHT: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b01) |=> (q == {$past(ser_hi), $past(q[MSB:1])})); // R3

    AST_SHIFT_LEFT: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b10) |=> (q == {$past(q[MSB-1:0]), $past(ser_lo)})); // R4

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b11) |=> $stable(q)); // R5

endmodule

// File: tb/bidir_shift3_test.sv
`timescale 1ns/1ps
module bidir_shift3_test;

    localparam int W = 3;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   mode = 2'b11;
    logic         ser_hi = 1'b0;
    logic         ser_lo = 1'b0;
    logic [W-1:0] q;

    int unsigned model = 0;
    string       tag = "R1";
    int          vectors = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    bidir_shift3 #(.WIDTH(W)) uut (
        .clk    (clk),
        .rst    (rst),
        .mode   (mode),
        .ser_hi (ser_hi),
        .ser_lo (ser_lo),
        .q      (q)
    );

    // Behavioural reference: integer shifts and masks.
    always @(posedge clk) begin
        if (rst) begin
            model = 0;
            tag = "R1";
        end else begin
            case (mode)
                2'b00: begin
                    model = 0;
                    tag = "R2";
                end
                2'b01: begin
                    model = (model >> 1) | (int'(ser_hi) << (W - 1));
                    tag = "R3 R6";
                end
                2'b10: begin
                    model = ((model << 1) | int'(ser_lo)) & ((1 << W) - 1);
                    tag = "R4 R6";
                end
                default: tag = "R5";
            endcase
        end
    end

    task automatic step(input bit r, input logic [1:0] m, input bit hi, input bit lo);
        @(negedge clk);
        vectors++;
        if (q !== model[W-1:0]) begin
            errors++;
            $display("FAIL %s: q=%b expected %b", tag, q, model[W-1:0]);
        end
        rst = r;
        mode = m;
        ser_hi = hi;
        ser_lo = lo;
    endtask

    initial begin
        #20000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: done=0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        step(1, 2'b01, 1, 1);           // R1 reset with a shift requested
        step(0, 2'b10, 0, 1);           // checks R1 reset state
        step(0, 2'b10, 1, 1);           // R4 fill from the low end
        step(0, 2'b10, 0, 1);
        step(0, 2'b11, 1, 0);           // R4 check, then hold with toggled inputs
        step(0, 2'b11, 0, 1);           // R5
        step(0, 2'b01, 0, 1);           // R5 check; right shift, ser_lo opposite (R6)
        step(0, 2'b01, 1, 0);           // R3
        step(0, 2'b10, 0, 1);           // R3 check; left shift, ser_hi opposite (R6)
        step(0, 2'b10, 1, 0);           // R4
        step(0, 2'b00, 1, 1);           // R4 check; clear
        step(0, 2'b10, 1, 1);           // R2 check
        step(0, 2'b10, 1, 1);
        step(1, 2'b11, 1, 1);           // R1 reset against hold
        step(0, 2'b01, 1, 0);           // R1 check
        for (int k = 0; k < 300; k++) begin
            step(($urandom % 16) == 0, 2'($urandom), 1'($urandom), 1'($urandom));
        end
        step(0, 2'b11, 0, 0);
        step(0, 2'b11, 0, 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule